// File: doc/BRIEF.md
# Clock-to-Signal Edge Delay Meter

This block watches two single-bit inputs on a fast sampling clock. One is a reference clock and the other is a signal that the reference drives. For each chosen reference edge, the block counts the sampling cycles until the next chosen signal edge. It reports that count as a delay value, qualified by a one-cycle valid strobe. Each input has its own edge choice: rising, falling or either.

A small pairing machine has two states: awaiting a reference edge, and awaiting a signal edge. It can take both steps on one sample, so a reference edge and a signal edge on the same sample give a delay of zero. Two edge kinds break the pairing, and each has its own saturating counter with a per-event strobe:
- reference edges that arrive while a signal edge is still pending;
- signal edges that arrive while no reference edge is open.

Timestamps come from a free-running sample counter, and delays are taken modulo its width. An optional synchronizer stage can be selected by parameter for inputs that are truly asynchronous.

Top module: `edge_delay_meter`

## Requirements
- R1: The edge-select encoding is the same for both inputs. 2'b00 picks rising edges: the previous sample is 0 and the current sample is 1. 2'b01 picks falling edges: 1 then 0. 2'b10 and 2'b11 pick any change between the previous and current samples.
- R2: A synchronous active-high reset has these effects:
  - it clears all outputs and both counters;
  - it clears the stored previous input values, so a reference input held high as reset ends is seen as a rising edge on the first sample;
  - it leaves the machine awaiting a reference edge.
- R3: Once a reference edge has opened a measurement at sample S, the next selected signal edge at sample E makes `meas_valid_o` high for exactly one cycle, with `meas_delay_o` = E − S. The result appears one clock after the sample that holds the signal edge.
- R4: A reference edge and a signal edge on the same sample, while a reference edge is awaited, give a measurement with delay 0.
- R5: While a signal edge is awaited, each further reference edge pulses `miss_ref_o` for one cycle and increments `miss_ref_cnt_o`. The open start time is kept.
- R6: While a reference edge is awaited, a signal edge pulses `miss_sig_o` and increments `miss_sig_cnt_o`. This happens only after at least one measurement has completed since reset. Before the first measurement such edges change no output.
- R7: A sample that closes a measurement and also holds a reference edge opens a new measurement starting at that sample. No miss is recorded for that sample.
- R8: Both miss counters are CNT_W bits wide and stop at their all-ones value. The event strobe still pulses for every miss event after the counter has saturated.
- R9: Delays are computed modulo 2^TS_W, so a measurement that spans the sample counter wrapping reports the true distance.
- R10: On any cycle, at most one of `meas_valid_o`, `miss_ref_o` and `miss_sig_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ref_i | input | 1 | Reference clock being observed |
| sig_i | input | 1 | Dependent signal being observed |
| ref_mode_i | input | 2 | Edge choice for the reference (R1 encoding) |
| sig_mode_i | input | 2 | Edge choice for the signal (R1 encoding) |
| meas_valid_o | output | 1 | One-cycle strobe for a finished measurement |
| meas_delay_o | output | TS_W | Delay in sample cycles; read it while the strobe is high |
| miss_ref_o | output | 1 | Strobe: extra reference edge seen while a signal edge was pending |
| miss_ref_cnt_o | output | CNT_W | Saturating count of extra reference edges |
| miss_sig_o | output | 1 | Strobe: stray signal edge seen while no measurement was open |
| miss_sig_cnt_o | output | CNT_W | Saturating count of stray signal edges |

## Verification
The block holds four pieces of internal state: the pairing state, the latched start stamp, the "signal seen" flag and the previous input samples. A fault in any of them shows at the ports one clock after the next sample that holds a selected edge:
- a wrong pairing state turns an expected measurement strobe into a miss strobe, or the reverse;
- a wrong start stamp shows as a wrong delay on the very next strobe;
- a wrong seen flag adds or drops a stray-signal miss on the first signal edge after reset.

The bench compares every cycle against a step-by-step model of the pairing rules. This exposes a divergence at the first edge that the faulty state affects.

// File: rtl/edm_pkg.sv
`timescale 1ns/1ps
package edm_pkg;

   typedef enum logic [1:0] {
      EDGE_RISE = 2'b00,
      EDGE_FALL = 2'b01,
      EDGE_ANY  = 2'b10,
      EDGE_ANY2 = 2'b11
   } edge_sel_e;

   typedef enum logic {
      ST_WAIT_REF = 1'b0,
      ST_WAIT_SIG = 1'b1
   } pair_st_e;

   function automatic logic edge_hit(input logic prev, input logic cur, input logic [1:0] sel);
      logic hit;
      case (edge_sel_e'(sel))
         EDGE_RISE: hit = ~prev & cur;
         EDGE_FALL: hit = prev & ~cur;
         default:   hit = prev ^ cur;
      endcase
      return hit;
   endfunction

endpackage

// File: rtl/edm_input_stage.sv
`timescale 1ns/1ps
module edm_input_stage #(
   parameter int SYNC_STAGES = 0
) (
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic       raw_i,
   input  logic [1:0] mode_i,
   output logic       edge_o
);
   import edm_pkg::*;

   logic cur_w;
   logic prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign cur_w = raw_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk_i) begin
            if (rst_i) chain_q <= '0;
            else       chain_q <= {chain_q[SYNC_STAGES-2:0], raw_i};
         end
         assign cur_w = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) prev_q <= 1'b0;
      else       prev_q <= cur_w;
   end

   assign edge_o = edge_hit(prev_q, cur_w, mode_i);

endmodule

// File: rtl/edm_sat_counter.sv
`timescale 1ns/1ps
module edm_sat_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             evt_i,
   output logic             pulse_o,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             pulse_q;
   logic [CNT_W-1:0] cnt_q;
   logic             can_inc;

   assign can_inc = evt_i && (cnt_q != CNT_MAX);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pulse_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         pulse_q <= evt_i;
         if (can_inc) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign pulse_o = pulse_q;
   assign cnt_o   = cnt_q;

endmodule

// File: rtl/edm_pair_fsm.sv
`timescale 1ns/1ps
module edm_pair_fsm #(
   parameter int TS_W = 32
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic            ref_edge_i,
   input  logic            sig_edge_i,
   output logic            valid_o,
   output logic [TS_W-1:0] delay_o,
   output logic            miss_ref_evt_o,
   output logic            miss_sig_evt_o
);
   import edm_pkg::*;

   pair_st_e        st_q, st_d;
   logic [TS_W-1:0] ts_q;
   logic [TS_W-1:0] start_q, start_d;
   logic            seen_q, seen_d;
   logic            done_w;
   logic [TS_W-1:0] dly_w;
   logic            valid_q;
   logic [TS_W-1:0] delay_q;

   always_comb begin
      st_d           = st_q;
      start_d        = start_q;
      seen_d         = seen_q;
      done_w         = 1'b0;
      dly_w          = '0;
      miss_ref_evt_o = 1'b0;
      miss_sig_evt_o = 1'b0;
      case (st_q)
         ST_WAIT_REF: begin
            if (ref_edge_i) begin
               start_d = ts_q;
               if (sig_edge_i) begin
                  done_w = 1'b1;
                  dly_w  = '0;
                  seen_d = 1'b1;
               end else begin
                  st_d = ST_WAIT_SIG;
               end
            end else if (sig_edge_i && seen_q) begin
               miss_sig_evt_o = 1'b1;
            end
         end
         default: begin
            if (sig_edge_i) begin
               done_w = 1'b1;
               dly_w  = ts_q - start_q;
               seen_d = 1'b1;
               if (ref_edge_i) start_d = ts_q;
               else            st_d    = ST_WAIT_REF;
            end else if (ref_edge_i) begin
               miss_ref_evt_o = 1'b1;
            end
         end
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         st_q    <= ST_WAIT_REF;
         ts_q    <= '0;
         start_q <= '0;
         seen_q  <= 1'b0;
         valid_q <= 1'b0;
         delay_q <= '0;
      end else begin
         st_q    <= st_d;
         ts_q    <= ts_q + 1'b1;
         start_q <= start_d;
         seen_q  <= seen_d;
         valid_q <= done_w;
         if (done_w) delay_q <= dly_w;
      end
   end

   assign valid_o = valid_q;
   assign delay_o = delay_q;

endmodule

// File: rtl/edge_delay_meter.sv
`timescale 1ns/1ps
module edge_delay_meter #(
   parameter int TS_W        = 32,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             ref_i,
   input  logic             sig_i,
   input  logic [1:0]       ref_mode_i,
   input  logic [1:0]       sig_mode_i,
   output logic             meas_valid_o,
   output logic [TS_W-1:0]  meas_delay_o,
   output logic             miss_ref_o,
   output logic [CNT_W-1:0] miss_ref_cnt_o,
   output logic             miss_sig_o,
   output logic [CNT_W-1:0] miss_sig_cnt_o
);
   localparam int N_IN = 2;

   generate
      if (TS_W < 2 || TS_W > 64) begin : g_bad_ts
         $error("edge_delay_meter: TS_W out of range");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("edge_delay_meter: CNT_W out of range");
      end
      if (SYNC_STAGES == 1 || SYNC_STAGES > 4 || SYNC_STAGES < 0) begin : g_bad_sync
         $error("edge_delay_meter: SYNC_STAGES must be 0, 2, 3 or 4");
      end
   endgenerate

   logic [N_IN-1:0] raw_w;
   logic [N_IN-1:0] edge_w;
   logic [1:0]      mode_w [N_IN];

   assign raw_w     = {sig_i, ref_i};
   assign mode_w[0] = ref_mode_i;
   assign mode_w[1] = sig_mode_i;

   for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
      edm_input_stage #(
         .SYNC_STAGES(SYNC_STAGES)
      ) u_stage (
         .clk_i (clk_i),
         .rst_i (rst_i),
         .raw_i (raw_w[gi]),
         .mode_i(mode_w[gi]),
         .edge_o(edge_w[gi])
      );
   end

   logic miss_ref_evt;
   logic miss_sig_evt;

   edm_pair_fsm #(
      .TS_W(TS_W)
   ) u_fsm (
      .clk_i         (clk_i),
      .rst_i         (rst_i),
      .ref_edge_i    (edge_w[0]),
      .sig_edge_i    (edge_w[1]),
      .valid_o       (meas_valid_o),
      .delay_o       (meas_delay_o),
      .miss_ref_evt_o(miss_ref_evt),
      .miss_sig_evt_o(miss_sig_evt)
   );

   edm_sat_counter #(
      .CNT_W(CNT_W)
   ) u_miss_ref (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .evt_i  (miss_ref_evt),
      .pulse_o(miss_ref_o),
      .cnt_o  (miss_ref_cnt_o)
   );

   edm_sat_counter #(
      .CNT_W(CNT_W)
   ) u_miss_sig (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .evt_i  (miss_sig_evt),
      .pulse_o(miss_sig_o),
      .cnt_o  (miss_sig_cnt_o)
   );

endmodule

// File: rtl/edm_checker.sv
`timescale 1ns/1ps
module edm_checker #(
   parameter int TS_W  = 32,
   parameter int CNT_W = 16
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             meas_valid_o,
   input logic [TS_W-1:0]  meas_delay_o,
   input logic             miss_ref_o,
   input logic [CNT_W-1:0] miss_ref_cnt_o,
   input logic             miss_sig_o,
   input logic [CNT_W-1:0] miss_sig_cnt_o
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   logic measured_q;
   always_ff @(posedge clk_i) begin
      if (rst_i)             measured_q <= 1'b0;
      else if (meas_valid_o) measured_q <= 1'b1;
   end

   AST_ONE_EVENT: assert property (@(posedge clk_i) disable iff (rst_i)
      $countones({meas_valid_o, miss_ref_o, miss_sig_o}) <= 1); // R10

   AST_REF_CNT_MOVES_ON_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
      (miss_ref_cnt_o != $past(miss_ref_cnt_o)) |-> miss_ref_o); // R5

   AST_REF_CNT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
      (miss_ref_o && $past(miss_ref_cnt_o) != CMAX) |-> miss_ref_cnt_o == $past(miss_ref_cnt_o) + 1'b1); // R8

   AST_REF_CNT_HOLD_MAX: assert property (@(posedge clk_i) disable iff (rst_i)
      ($past(miss_ref_cnt_o) == CMAX) |-> miss_ref_cnt_o == CMAX); // R8

   AST_SIG_CNT_MOVES_ON_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
      (miss_sig_cnt_o != $past(miss_sig_cnt_o)) |-> miss_sig_o); // R6

   AST_SIG_CNT_HOLD_MAX: assert property (@(posedge clk_i) disable iff (rst_i)
      ($past(miss_sig_cnt_o) == CMAX) |-> miss_sig_cnt_o == CMAX); // R8

   AST_SIG_MISS_AFTER_MEAS: assert property (@(posedge clk_i) disable iff (rst_i)
      miss_sig_o |-> measured_q); // R6

   AST_DELAY_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
      !meas_valid_o |-> $stable(meas_delay_o)); // R3

endmodule

bind edge_delay_meter edm_checker #(
   .TS_W (TS_W),
   .CNT_W(CNT_W)
) u_chk (
   .clk_i         (clk_i),
   .rst_i         (rst_i),
   .meas_valid_o  (meas_valid_o),
   .meas_delay_o  (meas_delay_o),
   .miss_ref_o    (miss_ref_o),
   .miss_ref_cnt_o(miss_ref_cnt_o),
   .miss_sig_o    (miss_sig_o),
   .miss_sig_cnt_o(miss_sig_cnt_o)
);

// File: tb/sim_edge_delay_meter.sv
`timescale 1ns/1ps
module sim_edge_delay_meter;
   localparam int TS_W  = 10;
   localparam int CNT_W = 4;
   localparam logic [CNT_W-1:0] CMAX = '1;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             ref_in = 1'b0;
   logic             sig_in = 1'b0;
   logic [1:0]       rmode = 2'b00;
   logic [1:0]       smode = 2'b00;
   logic             valid;
   logic [TS_W-1:0]  delay;
   logic             mref;
   logic [CNT_W-1:0] mref_cnt;
   logic             msig;
   logic [CNT_W-1:0] msig_cnt;

   int checks = 0;
   int errors = 0;
   string tag = "R2";

   always #2.5 clk = ~clk;

   edge_delay_meter #(.TS_W(TS_W), .CNT_W(CNT_W), .SYNC_STAGES(0)) u0 (
      .clk_i(clk), .rst_i(rst), .ref_i(ref_in), .sig_i(sig_in),
      .ref_mode_i(rmode), .sig_mode_i(smode),
      .meas_valid_o(valid), .meas_delay_o(delay),
      .miss_ref_o(mref), .miss_ref_cnt_o(mref_cnt),
      .miss_sig_o(msig), .miss_sig_cnt_o(msig_cnt));

   // reference model state
   bit              m_wait_sig;
   bit              m_seen;
   bit              m_pref, m_psig;
   logic [TS_W-1:0] m_ts, m_start;
   logic [CNT_W-1:0] m_cref, m_csig;

   function automatic bit sel_edge(bit p, bit c, logic [1:0] m);
      if (m == 2'b00) return !p && c;
      if (m == 2'b01) return p && !c;
      return p != c;
   endfunction

   task automatic chk(string t, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", t, what, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_wait_sig = 0; m_seen = 0; m_pref = 0; m_psig = 0;
      m_ts = '0; m_start = '0; m_cref = '0; m_csig = '0;
   endtask

   task automatic step(bit r, bit s);
      bit re, se, e_valid, e_mref, e_msig;
      logic [TS_W-1:0] e_dly;
      @(negedge clk);
      ref_in = r; sig_in = s;
      re = sel_edge(m_pref, r, rmode);
      se = sel_edge(m_psig, s, smode);
      e_valid = 0; e_mref = 0; e_msig = 0; e_dly = '0;
      if (!m_wait_sig) begin
         if (re) begin
            m_start = m_ts;
            if (se) begin e_valid = 1; e_dly = '0; m_seen = 1; end
            else m_wait_sig = 1;
         end else if (se && m_seen) e_msig = 1;
      end else begin
         if (se) begin
            e_valid = 1; e_dly = m_ts - m_start; m_seen = 1;
            if (re) m_start = m_ts; else m_wait_sig = 0;
         end else if (re) e_mref = 1;
      end
      if (e_mref && m_cref != CMAX) m_cref++;
      if (e_msig && m_csig != CMAX) m_csig++;
      m_pref = r; m_psig = s; m_ts++;
      @(posedge clk); #1;
      chk(tag, "valid", valid, e_valid);
      if (e_valid) chk(tag, "delay", delay, e_dly);
      chk(tag, "miss_ref pulse", mref, e_mref);
      chk(tag, "miss_ref count", mref_cnt, m_cref);
      chk(tag, "miss_sig pulse", msig, e_msig);
      chk(tag, "miss_sig count", msig_cnt, m_csig);
      chk("R10", "one event", int'(valid) + int'(mref) + int'(msig) <= 1, 1);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1; ref_in = 0; sig_in = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 0;
      model_reset();
   endtask

   initial begin : watchdog
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      // R2: outputs cleared during reset
      chk("R2", "valid in reset", valid, 0);
      chk("R2", "ref count in reset", mref_cnt, 0);
      chk("R2", "sig count in reset", msig_cnt, 0);
      do_reset();

      // R6: stray signal edges before any measurement are ignored
      tag = "R6";
      step(0, 1); step(0, 0); step(0, 1); step(0, 0);
      // R3: plain measurement, delay 3
      tag = "R3";
      step(1, 0); step(1, 0); step(0, 0); step(0, 1); step(0, 0);
      // R6: now stray signal edges count
      tag = "R6";
      step(0, 1); step(0, 0);
      // R5: extra reference edges while awaiting signal
      tag = "R5";
      step(1, 0); step(0, 0); step(1, 0); step(0, 0); step(1, 0); step(0, 1);
      // R4: coincident edges give zero
      tag = "R4";
      step(0, 0); step(1, 1); step(0, 0);
      // R7: closing and reopening on one sample
      tag = "R7";
      step(1, 0); step(0, 0); step(1, 1); step(0, 0); step(0, 0); step(0, 0);
      step(0, 1); step(0, 0);
      // R1: falling and any-change selections
      tag = "R1";
      rmode = 2'b01; smode = 2'b10;
      step(1, 0); step(0, 0); step(0, 1); step(1, 1); step(0, 1); step(0, 0);
      rmode = 2'b11; smode = 2'b01;
      step(1, 1); step(1, 1); step(1, 0); step(0, 0);
      rmode = 2'b00; smode = 2'b00;

      // R2: reference high as reset ends is a rising edge on sample 0
      do_reset();
      tag = "R2";
      step(1, 0); step(1, 0); step(1, 1);

      // R8: saturate the reference miss counter
      tag = "R8";
      for (int i = 0; i < 20; i++) begin step(0, 1); step(1, 1); end
      chk("R8", "ref count saturated", mref_cnt, CMAX);
      step(0, 0);

      // R9: measurement across timestamp wrap
      tag = "R9";
      while (m_ts != {TS_W{1'b1}} - 10'd2) step(0, 0);
      step(1, 0); step(0, 0); step(0, 0); step(0, 0); step(0, 0); step(0, 1);
      step(0, 0);

      // random traffic mixing all rules
      do_reset();
      tag = "R3 R5 R6 R7";
      for (int i = 0; i < 6000; i++) begin
         if (i % 250 == 0) begin
            rmode = 2'($urandom_range(0, 3));
            smode = 2'($urandom_range(0, 3));
         end
         step(($urandom_range(0, 3) == 0) ? !m_pref : m_pref,
              ($urandom_range(0, 2) == 0) ? !m_psig : m_psig);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule